// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Handler

This block services vectored interrupts for a bus master. It watches seven active-low request lines, one per interrupt level, and when the host-side vector register is free it asks for bus mastership. When the grant arrives it takes the highest pending level and runs a status/ID read. During that read it drives the start of an acknowledge daisy chain low and puts the level on a three-bit level bus. The slave that answers returns an 8-bit vector and strobes an acknowledge. The handler stores the vector together with the level and an error bit, and it raises a host interrupt.

The host interrupt stays high, and the stored word stays unchanged, until the host pulses a read strobe. No new acknowledge cycle can start before that read. If no slave answers within a fixed number of cycles, the cycle ends with the error bit set and a zero vector.

A small combinational pass-through cell for slave slots is also provided. Each slot wires one cell into the acknowledge chain. The cell passes the chain onward unless its own slot is requesting at the level being served, in which case it stops the chain and claims the cycle. The slot nearest the handler therefore wins among slots on the same level.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, bus_req is 0, ack_n is 1, host_irq is 0 and host_vec is 0.
- R2: When host_irq is low and any irq_n line is low, bus_req goes high. ack_n goes low only after bus_grant has been sampled high, and while ack_n is low bus_req stays high.
- R3: The served level is the highest-numbered low request line in the cycle bus_grant is sampled, where line irq_n[L-1] carries level L and level 7 ranks highest. ack_lvl shows that level and holds steady while ack_n is low.
- R4: If no request line is low in the cycle bus_grant is sampled, bus_req drops, ack_n stays high and no host interrupt is raised.
- R5: In the first acknowledge cycle in which dtack_n is sampled low, vec_in is captured. host_vec becomes {1'b0, level[2:0], vector[7:0]} (bit 11 is the error bit, bits 10:8 the level, bits 7:0 the vector), ack_n and bus_req are released and host_irq rises.
- R6: If dtack_n is not sampled low within TMO cycles of ack_n low, the cycle ends with host_vec = {1'b1, level, 8'h00} and host_irq high. A response in the last of those cycles still counts as success.
- R7: While host_irq is high, host_vec holds its value, bus_req stays 0 and ack_n stays 1 whatever the request lines do. A cycle with host_rd high clears host_irq at the next edge.
- R8: The pass-through cell drives ack_out_n equal to ack_in_n, except when its own level is nonzero and equals ack_lvl. In that case ack_out_n is 1, and sel is 1 exactly when ack_in_n is 0.
- R9: When several slots request the same level, the slot nearest the handler on the chain supplies the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | NLVL | Active-low request lines; bit L-1 carries level L |
| bus_req | output | 1 | Request for bus mastership |
| bus_grant | input | 1 | Mastership granted |
| ack_n | output | 1 | Active-low acknowledge, head of the daisy chain |
| ack_lvl | output | LW | Level being acknowledged, on the low address lines |
| dtack_n | input | 1 | Active-low slave response strobe |
| vec_in | input | VW | Vector returned by the slave |
| host_rd | input | 1 | Host read strobe for the vector register |
| host_vec | output | 1+LW+VW | {error, level, vector} register |
| host_irq | output | 1 | Host interrupt, high until host_rd |

## Verification
Two events can land on the same clock edge: the slave's response strobe and the expiry of the response timer. The bench provokes the collision by setting a slot's reply delay to TMO-1 cycles, and it also tries TMO cycles. It expects a clean vector in the first case and the error word in the second. A second overlap is a host read that arrives while new requests are already pending. The bench checks that nothing starts on the bus before the read, and that a fresh cycle follows right after it.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_ACK,
        ST_HOLD
    } ack_st_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NLVL = 7,
    parameter int LW   = 3
) (
    input  logic [NLVL-1:0] req_n,
    output logic [LW-1:0]   top_lvl,
    output logic            any_req
);

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (!req_n[i]) top_lvl = LW'(i + 1);
        end
        any_req = |(~req_n);
    end

endmodule

// File: rtl/ack_timer.sv
module ack_timer #(
    parameter int TMO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(TMO + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = run ? cnt_q + CW'(1) : '0;
        expire = run && (cnt_q == CW'(TMO - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
    parameter int LW = 3
) (
    input  logic          ack_in_n,
    input  logic [LW-1:0] ack_lvl,
    input  logic [LW-1:0] own_lvl,
    output logic          ack_out_n,
    output logic          sel
);

    logic hit;

    always_comb begin
        hit       = (own_lvl != '0) && (own_lvl == ack_lvl);
        ack_out_n = ack_in_n | hit;
        sel       = !ack_in_n && hit;
    end

    // R8: a low output is only ever a forwarded low, never with a claim
    always_comb begin
        if (!ack_out_n) begin
            a_r8_pass_only: assert (!ack_in_n && !sel);
        end
    end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int NLVL = 7,
    parameter int VW   = 8,
    parameter int TMO  = 16,
    localparam int LW  = $clog2(NLVL + 1),
    localparam int HW  = 1 + LW + VW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] irq_n,
    output logic            bus_req,
    input  logic            bus_grant,
    output logic            ack_n,
    output logic [LW-1:0]   ack_lvl,
    input  logic            dtack_n,
    input  logic [VW-1:0]   vec_in,
    input  logic            host_rd,
    output logic [HW-1:0]   host_vec,
    output logic            host_irq
);

    typedef struct packed {
        ack_st_e       st;
        logic [LW-1:0] lvl;
        logic [VW-1:0] vec;
        logic          err;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [LW-1:0] enc_lvl;
    logic          enc_any;
    logic          tmr_exp;

    irq_prio_enc #(.NLVL(NLVL), .LW(LW)) u_enc (
        .req_n   (irq_n),
        .top_lvl (enc_lvl),
        .any_req (enc_any)
    );

    ack_timer #(.TMO(TMO)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl_q.st == ST_ACK),
        .expire (tmr_exp)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (enc_any) ctl_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (bus_grant) begin
                    if (enc_any) begin
                        ctl_d.st  = ST_ACK;
                        ctl_d.lvl = enc_lvl;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            ST_ACK: begin
                if (!dtack_n) begin
                    ctl_d.st  = ST_HOLD;
                    ctl_d.vec = vec_in;
                    ctl_d.err = 1'b0;
                end else if (tmr_exp) begin
                    ctl_d.st  = ST_HOLD;
                    ctl_d.vec = '0;
                    ctl_d.err = 1'b1;
                end
            end
            ST_HOLD: begin
                if (host_rd) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, lvl: '0, vec: '0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_req  = (ctl_q.st == ST_REQ) || (ctl_q.st == ST_ACK);
        ack_n    = (ctl_q.st != ST_ACK);
        ack_lvl  = ctl_q.lvl;
        host_irq = (ctl_q.st == ST_HOLD);
        host_vec = {ctl_q.err, ctl_q.lvl, ctl_q.vec};
    end

    // ---------------- assertions ----------------
    logic [NLVL-1:0] irq_prev;
    logic [31:0]     ack_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_prev <= '1;
            ack_run  <= '0;
        end else begin
            irq_prev <= irq_n;
            ack_run  <= ack_n ? 32'd0 : ack_run + 32'd1;
        end
    end

    a_r2_master_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> bus_req);

    a_r3_lvl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !$past(ack_n)) |-> $stable(ack_lvl));

    a_r3_highest: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> ((ack_lvl != '0) && (((~irq_prev) >> ack_lvl) == '0)
                          && (irq_prev[ack_lvl - LW'(1)] == 1'b0)));

    a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (ack_run < 32'(TMO)));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !host_rd) |=> (host_irq && $stable(host_vec)));

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (ack_n && !bus_req));

endmodule

// File: tb/irq_ack_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ack_ctrl_tb;

    localparam int NLVL = 7;
    localparam int VW   = 8;
    localparam int TMO  = 16;
    localparam int LW   = 3;
    localparam int HW   = 1 + LW + VW;
    localparam int NS   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NLVL-1:0] irq_n;
    logic            bus_req, bus_grant = 1'b0;
    logic            ack_n;
    logic [LW-1:0]   ack_lvl;
    logic            dtack_n;
    logic [VW-1:0]   vec_in;
    logic            host_rd = 1'b0;
    logic [HW-1:0]   host_vec;
    logic            host_irq;

    logic [LW-1:0] slot_lvl [NS];
    logic [VW-1:0] slot_vec [NS];
    int            slot_dly [NS];
    logic [NS:0]   chain;
    logic [NS-1:0] sel;
    int            rcnt = 0;
    int            total = 0, bad = 0, cyc = 0;
    bit            gnt_en = 1'b1;

    always #2.5 clk = ~clk;

    irq_ack_ctrl #(.NLVL(NLVL), .VW(VW), .TMO(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .bus_req(bus_req),
        .bus_grant(bus_grant), .ack_n(ack_n), .ack_lvl(ack_lvl),
        .dtack_n(dtack_n), .vec_in(vec_in), .host_rd(host_rd),
        .host_vec(host_vec), .host_irq(host_irq)
    );

    assign chain[0] = ack_n;
    for (genvar k = 0; k < NS; k++) begin : g_slot
        irq_chain_cell #(.LW(LW)) u_cell (
            .ack_in_n(chain[k]), .ack_lvl(ack_lvl), .own_lvl(slot_lvl[k]),
            .ack_out_n(chain[k+1]), .sel(sel[k])
        );
    end

    always_comb begin
        irq_n = '1;
        for (int k = 0; k < NS; k++)
            if (slot_lvl[k] != '0) irq_n[slot_lvl[k] - 1] = 1'b0;
    end

    always_comb begin
        dtack_n = 1'b1;
        vec_in  = '0;
        for (int k = 0; k < NS; k++)
            if (sel[k] && rcnt >= slot_dly[k]) begin
                dtack_n = 1'b0;
                vec_in  = slot_vec[k];
            end
    end

    always @(posedge clk) begin
        rcnt      <= (|sel) ? rcnt + 1 : 0;
        bus_grant <= bus_req && gnt_en && ($urandom % 3 != 0);
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // expected result of one service, from the slot table
    function automatic logic [HW-1:0] expect_word(output int win);
        logic [LW-1:0] lv = '0;
        win = -1;
        for (int k = 0; k < NS; k++) if (slot_lvl[k] > lv) lv = slot_lvl[k];
        for (int k = NS - 1; k >= 0; k--) if (slot_lvl[k] == lv && lv != '0) win = k;
        if (win < 0) return '0;
        if (slot_dly[win] >= TMO) return {1'b1, lv, 8'h00};
        return {1'b0, lv, slot_vec[win]};
    endfunction

    task automatic serve(string req);
        int            win;
        logic [HW-1:0] exp = expect_word(win);
        int            n = 0;
        while (!host_irq && n < 2000) begin
            @(negedge clk); n++;
            if (!ack_n) begin
                for (int k = 0; k < NS; k++)
                    chk("R8 chain", chain[k+1],
                        chain[k] | (slot_lvl[k] != 0 && slot_lvl[k] == ack_lvl));
            end
        end
        chk({req, " R5/R6 host_vec"}, host_vec, exp);
        chk("R7 irq high", host_irq, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R7 no bus activity", {bus_req, ack_n, host_irq}, 3'b011);
            chk("R7 vec held", host_vec, exp);
        end
        if (win >= 0) slot_lvl[win] = '0;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R7 irq cleared", host_irq, 1'b0);
    endtask

    task automatic drain(string req);
        int n = 0;
        while (irq_n != '1 && n < 20) begin
            serve(req); n++;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < NS; k++) begin
            slot_lvl[k] = '0; slot_vec[k] = 8'(8'h10 + k); slot_dly[k] = 1;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset", {bus_req, ack_n, host_irq, host_vec}, {3'b010, 12'h000});
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: single request, then priority among levels
        slot_lvl[2] = 3'd4; slot_vec[2] = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        chk("R2 bus_req", bus_req, 1'b1);
        serve("R2");
        slot_lvl[0] = 3'd2; slot_lvl[1] = 3'd7; slot_lvl[3] = 3'd5;
        serve("R3 top level 7");
        serve("R3 next level 5");
        serve("R3 last level 2");

        // R9: same level, nearest slot wins
        slot_lvl[1] = 3'd3; slot_vec[1] = 8'h3C;
        slot_lvl[3] = 3'd3; slot_vec[3] = 8'hC3;
        serve("R9 nearest");
        serve("R9 farther");

        // R6: reply in last allowed cycle vs one cycle late
        slot_lvl[0] = 3'd6; slot_dly[0] = TMO - 1; slot_vec[0] = 8'h77;
        serve("R6 last cycle ok");
        slot_lvl[0] = 3'd6; slot_dly[0] = TMO;
        serve("R6 timeout");
        slot_dly[0] = 1;

        // R7: requests pending during hold, new cycle only after read
        slot_lvl[2] = 3'd1; slot_lvl[3] = 3'd2;
        serve("R7 first");
        @(negedge clk);
        chk("R7 restart after read", bus_req, 1'b1);
        drain("R7");

        // R4: request withdrawn before grant
        gnt_en = 1'b0;
        slot_lvl[1] = 3'd5;
        repeat (3) @(negedge clk);
        chk("R4 req up", bus_req, 1'b1);
        slot_lvl[1] = '0;
        @(negedge clk);
        gnt_en = 1'b1;
        begin
            bit saw_ack = 1'b0;
            repeat (20) begin @(negedge clk); if (!ack_n) saw_ack = 1'b1; end
            chk("R4 no ack", saw_ack, 1'b0);
            chk("R4 released", {bus_req, host_irq}, 2'b00);
        end

        // random mix
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < NS; k++) begin
                slot_lvl[k] = LW'($urandom % 8);
                slot_vec[k] = VW'($urandom);
                slot_dly[k] = ($urandom % 4 == 0) ? TMO - 1 + int'($urandom % 3)
                                                  : int'($urandom % 5);
            end
            drain("R3/R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule